// File: doc/BRIEF.md
# Five-Lane Packed RGB to YUV Stream Converter

This block converts a stream of packed colour pixels from RGB to YUV. Each 128-bit input beat carries up to five pixels of three 8-bit components each. All five lanes are converted in parallel, so the block returns one beat for every beat it accepts. Each output beat keeps the lane layout of its input beat. The luma Y is a weighted sum of the three colour components. The two chroma values are scaled differences: U is taken against blue and V against red, each relative to the freshly computed luma. All arithmetic is fixed point.

A beat enters through a valid/ready handshake together with a lane count, which says how many of the low lanes hold pixels. A short final beat of an image therefore needs no special framing. The datapath is a two-stage pipeline. The first stage forms the weighted products and the second sums, rounds and scales them into the output register. Both stages stall together whenever the output register holds a beat that downstream has not yet taken.

Top module: `rgbyuv_pack5`

## Requirements
- R1: Lane k occupies bits [24k+23:24k] of a beat. On input, R is in the low byte of the lane, G in the middle byte and B in the high byte. On output, Y, U and V occupy those same three byte slots in that order.
- R2: Y of an active lane equals 0.299·R + 0.587·G + 0.114·B within ±1, rounded to nearest. The values are exact for primaries and greys, for example (255,0,0) gives 76, (0,255,0) gives 150 and (128,128,128) gives 128.
- R3: U equals 0.492·(B − Y) within ±1, where Y is the lane's output luma. A negative result wraps to its low 8 bits in two's complement, so the ±1 tolerance is measured modulo 256.
- R4: V equals 0.877·(R − Y) within ±1, with Y and the wrap handled as in R3.
- R5: Bits 127:120 of an input beat have no effect on the output. Bits 127:120 of every output beat are zero.
- R6: Lane k is active when k < in_lanes, where in_lanes is an unsigned count from 0 to 5. Inactive lanes read as zero on output whatever their input bits hold. The count is delivered unchanged on out_lanes with the beat.
- R7: If the output is not stalled, a beat accepted at clock edge n is presented with out_valid high after edge n+1.
- R8: While out_valid is high and out_ready is low, out_data and out_lanes hold steady and in_ready is low.
- R9: Beats leave in the order they were accepted, with none dropped or repeated under any pattern of out_ready.
- R10: A synchronous reset empties the pipeline. After reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat at this edge |
| in_data | input | 128 | Packed RGB beat, five 24-bit lanes |
| in_lanes | input | 3 | Number of active low lanes, 0 to 5 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 128 | Packed YUV beat |
| out_lanes | output | 3 | Lane count that travelled with the beat |

## Verification
The hardest case to reach is a full pipeline under stall. In that case the output register holds a beat that has not been taken, a second beat sits in the product stage, and a third is offered at the input. The bench gets there by holding out_ready low and offering two beats back to back. It then checks that in_ready stays low and the output stays frozen for several cycles. After that, a long run with out_ready driven from a shift-register pattern checks ordering and completeness beat by beat against a queue of expected beats. Partial beats carry junk in their inactive lanes and in the top byte, so zeroing shows up at the ports.

// File: rtl/rgbyuv_pkg.sv
package rgbyuv_pkg;
   localparam int NCOMP = 3;
   // weights in thousandths
   localparam int W_YR = 299;
   localparam int W_YG = 587;
   localparam int W_YB = 114;
   localparam int W_U  = 492;
   localparam int W_V  = 877;

   // weight in thousandths to a rounded fixed-point fraction with frac bits
   function automatic int coef(input int milli, input int frac);
      return (milli * (2 ** frac) + 500) / 1000;
   endfunction
endpackage

// File: rtl/rgbyuv_lane_mul.sv
module rgbyuv_lane_mul #(
   parameter int CW   = 8,
   parameter int FRAC = 10
) (
   input  logic [CW-1:0]      r,
   input  logic [CW-1:0]      g,
   input  logic [CW-1:0]      b,
   output logic [CW+FRAC-1:0] pr,
   output logic [CW+FRAC-1:0] pg,
   output logic [CW+FRAC-1:0] pb
);
   import rgbyuv_pkg::*;
   localparam int PW = CW + FRAC;
   localparam int KR = coef(W_YR, FRAC);
   localparam int KG = coef(W_YG, FRAC);
   localparam int KB = coef(W_YB, FRAC);

   assign pr = PW'(r) * PW'(KR);
   assign pg = PW'(g) * PW'(KG);
   assign pb = PW'(b) * PW'(KB);
endmodule

// File: rtl/rgbyuv_lane_fin.sv
module rgbyuv_lane_fin #(
   parameter int CW   = 8,
   parameter int FRAC = 10
) (
   input  logic [CW+FRAC-1:0] pr,
   input  logic [CW+FRAC-1:0] pg,
   input  logic [CW+FRAC-1:0] pb,
   input  logic [CW-1:0]      r,
   input  logic [CW-1:0]      b,
   output logic [CW-1:0]      y,
   output logic [CW-1:0]      u,
   output logic [CW-1:0]      v
);
   import rgbyuv_pkg::*;
   localparam int PW   = CW + FRAC;
   localparam int SW   = PW + 2;
   localparam int MW   = CW + FRAC + 2;
   localparam int HALF = 2 ** (FRAC - 1);
   localparam int KU   = coef(W_U, FRAC);
   localparam int KV   = coef(W_V, FRAC);

   logic [SW-1:0]        sum;
   logic signed [CW:0]   db;
   logic signed [CW:0]   dr;
   logic signed [MW-1:0] su;
   logic signed [MW-1:0] sv;

   // luma: weighted sum, round half up, keep integer byte
   assign sum = SW'(pr) + SW'(pg) + SW'(pb) + SW'(HALF);
   assign y   = sum[FRAC +: CW];

   // chroma: signed differences against the output luma
   assign db = $signed({1'b0, b}) - $signed({1'b0, y});
   assign dr = $signed({1'b0, r}) - $signed({1'b0, y});
   assign su = MW'(db) * MW'(KU) + MW'(HALF);
   assign sv = MW'(dr) * MW'(KV) + MW'(HALF);
   // low byte of the arithmetic right shift wraps like an integer cast
   assign u  = su[FRAC +: CW];
   assign v  = sv[FRAC +: CW];

   logic unused_fin;
   assign unused_fin = ^{sum[FRAC-1:0], sum[SW-1:FRAC+CW],
                         su[FRAC-1:0], su[MW-1:FRAC+CW],
                         sv[FRAC-1:0], sv[MW-1:FRAC+CW]};
endmodule

// File: rtl/rgbyuv_pack5.sv
module rgbyuv_pack5 #(
   parameter int WORD_W = 128,
   parameter int LANES  = 5,
   parameter int CW     = 8,
   parameter int FRAC   = 10
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           in_valid,
   output logic                           in_ready,
   input  logic [WORD_W-1:0]              in_data,
   input  logic [$clog2(LANES+1)-1:0]     in_lanes,
   output logic                           out_valid,
   input  logic                           out_ready,
   output logic [WORD_W-1:0]              out_data,
   output logic [$clog2(LANES+1)-1:0]     out_lanes
);
   import rgbyuv_pkg::*;
   localparam int LW   = NCOMP * CW;
   localparam int USED = LANES * LW;
   localparam int NW   = $clog2(LANES + 1);
   localparam int PW   = CW + FRAC;

   // elaboration-time parameter checks
   if (USED > WORD_W) begin : g_chk_width
      $error("lanes do not fit in the beat width");
   end
   if (FRAC < 4 || FRAC > 16) begin : g_chk_frac
      $error("fraction width out of range");
   end
   if (LANES < 1) begin : g_chk_lanes
      $error("at least one lane required");
   end

   logic          advance;
   logic          s1_valid;
   logic [NW-1:0] s1_lanes;
   logic          o_valid_q;
   logic [NW-1:0] o_lanes_q;

   // whole pipeline moves when the output register is free or being taken
   assign advance   = !o_valid_q || out_ready;
   assign in_ready  = advance;
   assign out_valid = o_valid_q;
   assign out_lanes = o_lanes_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid  <= 1'b0;
         o_valid_q <= 1'b0;
      end else if (advance) begin
         s1_valid  <= in_valid;
         o_valid_q <= s1_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (advance) begin
         s1_lanes  <= in_lanes;
         o_lanes_q <= s1_lanes;
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic          act;
      logic [CW-1:0] r_i, g_i, b_i;
      logic [PW-1:0] pr_d, pg_d, pb_d;
      logic [PW-1:0] pr_q, pg_q, pb_q;
      logic [CW-1:0] r_q, b_q;
      logic [CW-1:0] y_d, u_d, v_d;
      logic [LW-1:0] lane_q;

      // an inactive lane is forced to black, which converts to all zeros
      assign act = NW'(k) < in_lanes;
      assign r_i = act ? in_data[k*LW        +: CW] : '0;
      assign g_i = act ? in_data[k*LW + CW   +: CW] : '0;
      assign b_i = act ? in_data[k*LW + 2*CW +: CW] : '0;

      rgbyuv_lane_mul #(.CW(CW), .FRAC(FRAC)) u_mul (
         .r (r_i), .g (g_i), .b (b_i),
         .pr(pr_d), .pg(pg_d), .pb(pb_d)
      );

      always_ff @(posedge clk) begin
         if (advance) begin
            pr_q <= pr_d;
            pg_q <= pg_d;
            pb_q <= pb_d;
            r_q  <= r_i;
            b_q  <= b_i;
         end
      end

      rgbyuv_lane_fin #(.CW(CW), .FRAC(FRAC)) u_fin (
         .pr(pr_q), .pg(pg_q), .pb(pb_q),
         .r (r_q),  .b (b_q),
         .y (y_d),  .u (u_d),  .v (v_d)
      );

      always_ff @(posedge clk) begin
         if (advance) lane_q <= {v_d, u_d, y_d};
      end

      assign out_data[k*LW +: LW] = lane_q;
   end

   if (WORD_W > USED) begin : g_pad
      assign out_data[WORD_W-1:USED] = '0;
      logic unused_pad;
      assign unused_pad = ^in_data[WORD_W-1:USED];
   end
endmodule

// File: rtl/rgbyuv_pack5_chk.sv
module rgbyuv_pack5_chk #(
   parameter int WORD_W = 128,
   parameter int LANES  = 5,
   parameter int CW     = 8
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       in_valid,
   input logic                       in_ready,
   input logic                       out_valid,
   input logic                       out_ready,
   input logic [WORD_W-1:0]          out_data,
   input logic [$clog2(LANES+1)-1:0] out_lanes
);
   localparam int LW   = 3 * CW;
   localparam int USED = LANES * LW;
   localparam int NW   = $clog2(LANES + 1);

   // beats inside the block: accepted minus delivered
   logic [2:0] occ;
   always_ff @(posedge clk) begin
      if (rst) occ <= '0;
      else occ <= occ + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_lanes));

   assert_block_in_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |-> !in_ready);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
      occ <= 3'd2);

   assert_no_phantom_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> occ != 3'd0);

   assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) ##1 (!out_valid || out_ready) |=> out_valid);

   if (WORD_W > USED) begin : g_top
      assert_top_zero_R5: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> out_data[WORD_W-1:USED] == '0);
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lz
      assert_idle_lane_R6: assert property (@(posedge clk) disable iff (rst)
         out_valid && out_lanes <= NW'(k) |-> out_data[k*LW +: LW] == '0);
   end
endmodule

bind rgbyuv_pack5 rgbyuv_pack5_chk #(.WORD_W(WORD_W), .LANES(LANES), .CW(CW)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .out_lanes(out_lanes)
);

// File: tb/tb_rgbyuv_pack5.sv
`timescale 1ns/1ps
module tb_rgbyuv_pack5;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_data = '0;
   logic [2:0]   in_lanes = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;
   logic [2:0]   out_lanes;

   int errors = 0;
   int checks = 0;
   int rmode  = 0;
   logic [15:0] lfsr = 16'hACE1;

   typedef struct packed {
      logic [127:0] w;
      logic [2:0]   n;
      logic         yh_en;
      logic [7:0]   yh;
   } exp_t;
   exp_t expq[$];

   // R, G, B, exact Y
   localparam int TBL [8][4] = '{
      '{0, 0, 0, 0},       '{255, 255, 255, 255}, '{255, 0, 0, 76},
      '{0, 255, 0, 150},   '{0, 0, 255, 29},      '{128, 128, 128, 128},
      '{255, 255, 0, 226}, '{0, 255, 255, 179}};

   always #4 clk = ~clk;

   rgbyuv_pack5 dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_lanes(in_lanes), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_lanes(out_lanes));

   task automatic chk(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s", msg);
      end
   endtask

   function automatic bit near(input real act, input real ref_v);
      real d;
      d = act - ref_v;
      while (d > 128.0) d = d - 256.0;
      while (d < -128.0) d = d + 256.0;
      return (d <= 1.0) && (d >= -1.0);
   endfunction

   function automatic logic [23:0] pix(input int i);
      logic [7:0] r, g, b;
      r = 8'((i * 37 + 11) & 255);
      g = 8'((i * 91 + 200) & 255);
      b = 8'((i * 53 + 7) & 255);
      return {b, g, r};
   endfunction

   // out_ready patterns, changed at the falling edge
   initial forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rmode)
         0: out_ready = 1'b1;
         1: out_ready = lfsr[0] | lfsr[3];
         default: out_ready = 1'b0;
      endcase
   end

   task automatic check_beat(input exp_t e);
      int bad_y, bad_u, bad_v, bad_z;
      string sy, su, sv, sz;
      bad_y = 0; bad_u = 0; bad_v = 0; bad_z = 0;
      chk(out_lanes == e.n, $sformatf("R6 lane count act=%0d exp=%0d", out_lanes, e.n));
      chk(out_data[127:120] == 8'h00,
          $sformatf("R5 top byte act=%0h exp=0", out_data[127:120]));
      for (int k = 0; k < 5; k++) begin
         logic [7:0] r, g, b, y, u, v;
         real yr, ur, vr;
         r = e.w[24*k +: 8]; g = e.w[24*k+8 +: 8]; b = e.w[24*k+16 +: 8];
         y = out_data[24*k +: 8]; u = out_data[24*k+8 +: 8]; v = out_data[24*k+16 +: 8];
         if (k < int'(e.n)) begin
            yr = 0.299 * r + 0.587 * g + 0.114 * b;
            ur = 0.492 * (real'(b) - real'(y));
            vr = 0.877 * (real'(r) - real'(y));
            if (!near(real'(y), yr) && bad_y == 0) begin
               bad_y = 1; sy = $sformatf("lane%0d act=%0d exp=%0.2f", k, y, yr);
            end
            if (!near(real'(u), ur) && bad_u == 0) begin
               bad_u = 1; su = $sformatf("lane%0d act=%0d exp=%0.2f mod 256", k, u, ur);
            end
            if (!near(real'(v), vr) && bad_v == 0) begin
               bad_v = 1; sv = $sformatf("lane%0d act=%0d exp=%0.2f mod 256", k, v, vr);
            end
         end else if ({v, u, y} != 24'h0 && bad_z == 0) begin
            bad_z = 1; sz = $sformatf("lane%0d act=%0h exp=0", k, {v, u, y});
         end
      end
      chk(bad_y == 0, {"R1 R2 luma ", sy});
      chk(bad_u == 0, {"R1 R3 blue chroma ", su});
      chk(bad_v == 0, {"R1 R4 red chroma ", sv});
      chk(bad_z == 0, {"R6 inactive lane ", sz});
      if (e.yh_en)
         chk(out_data[7:0] == e.yh,
             $sformatf("R2 table luma act=%0d exp=%0d", out_data[7:0], e.yh));
   endtask

   // monitor: every delivered beat is compared in order with the queue
   initial forever begin
      @(negedge clk);
      #2;
      if (!rst && out_valid && out_ready) begin
         if (expq.size() == 0) chk(1'b0, "R9 unexpected beat act=1 exp=0");
         else check_beat(expq.pop_front());
      end
   end

   task automatic send(input logic [127:0] w, input logic [2:0] n,
                       input bit yh_en, input logic [7:0] yh);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; in_data = w; in_lanes = n;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      e.w = w; e.n = n; e.yh_en = yh_en; e.yh = yh;
      expq.push_back(e);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   function automatic logic [127:0] mkbeat(input int seed, input int n);
      logic [127:0] w;
      w[127:120] = 8'hA5;
      for (int k = 0; k < 5; k++)
         w[24*k +: 24] = (k < n) ? pix(seed * 5 + k) : 24'hC3_5A_E7 ^ 24'(k);
      return w;
   endfunction

   task automatic drain();
      while (expq.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      logic [127:0] held;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk); #1;
      chk(out_valid == 1'b0, $sformatf("R10 out_valid after reset act=%0b exp=0", out_valid));
      chk(in_ready == 1'b1, $sformatf("R10 in_ready after reset act=%0b exp=1", in_ready));

      // table walk: every lane holds the table pixel, top byte junk
      for (int i = 0; i < 8; i++) begin
         logic [127:0] w;
         w[127:120] = 8'hFF;
         for (int k = 0; k < 5; k++)
            w[24*k +: 24] = {8'(TBL[i][2]), 8'(TBL[i][1]), 8'(TBL[i][0])};
         send(w, 3'd5, 1'b1, 8'(TBL[i][3]));
      end
      drain();

      // R7 latency on an idle pipeline
      @(negedge clk);
      in_valid = 1'b1; in_data = mkbeat(40, 5); in_lanes = 3'd5;
      expq.push_back('{w: mkbeat(40, 5), n: 3'd5, yh_en: 1'b0, yh: 8'd0});
      @(posedge clk); #1 in_valid = 1'b0;
      @(negedge clk); #1;
      chk(out_valid == 1'b0, $sformatf("R7 one edge after accept act=%0b exp=0", out_valid));
      @(negedge clk); #1;
      chk(out_valid == 1'b1, $sformatf("R7 two edges after accept act=%0b exp=1", out_valid));
      drain();

      // R6 partial beats, counts 0 to 4, junk in idle lanes
      for (int n = 0; n < 5; n++) send(mkbeat(50 + n, n), 3'(n), 1'b0, 8'd0);
      drain();

      // R8 full pipeline under stall
      rmode = 2;
      send(mkbeat(60, 5), 3'd5, 1'b0, 8'd0);
      send(mkbeat(61, 3), 3'd3, 1'b0, 8'd0);
      @(negedge clk); #1;
      chk(out_valid && !in_ready,
          $sformatf("R8 stalled act valid=%0b ready=%0b exp valid=1 ready=0", out_valid, in_ready));
      held = out_data;
      in_valid = 1'b1; in_data = mkbeat(62, 5); in_lanes = 3'd5;
      repeat (4) @(negedge clk);
      #1;
      chk(out_data == held, $sformatf("R8 held data act=%0h exp=%0h", out_data, held));
      chk(in_ready == 1'b0, $sformatf("R8 ready while held act=%0b exp=0", in_ready));
      in_valid = 1'b0;
      rmode = 0;
      drain();

      // R9 long run under random backpressure
      rmode = 1;
      for (int i = 0; i < 60; i++) send(mkbeat(100 + i, (i % 6)), 3'(i % 6), 1'b0, 8'd0);
      rmode = 0;
      drain();
      chk(expq.size() == 0, $sformatf("R9 beats left act=%0d exp=0", expq.size()));

      // R10 reset in the middle of a stalled transfer
      rmode = 2;
      send(mkbeat(200, 5), 3'd5, 1'b0, 8'd0);
      send(mkbeat(201, 5), 3'd5, 1'b0, 8'd0);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      expq.delete();
      @(negedge clk); #1;
      chk(out_valid == 1'b0, $sformatf("R10 flushed act=%0b exp=0", out_valid));
      chk(in_ready == 1'b1, $sformatf("R10 ready after flush act=%0b exp=1", in_ready));
      rmode = 0;
      repeat (4) @(negedge clk);
      #1;
      chk(out_valid == 1'b0, $sformatf("R10 no stale beat act=%0b exp=0", out_valid));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule